// File: doc/BRIEF.md
# Split-Operation Store Buffer with Load Disambiguation

This block holds stores that have issued but not yet been written to memory, for a simple load-store unit. A store reaches it as two separate operations. The address operation claims a free slot, records the target address and returns the slot number as a tag. The data operation comes later, in the same or any following cycle, and carries that tag together with the value to be stored. Because the address is captured on its own, younger loads can be checked against a store whose data has not been produced yet.

Each load is compared in the same cycle against every occupied slot. If the youngest matching slot already holds its data, the load is answered from the buffer and memory is not read. If that slot is still waiting for its data, the load is held with a stall flag. If no slot matches, the load goes to the memory read port, whatever other stores are still waiting for data. A load never takes a slot. Slots are compared using the state registered at the start of the cycle, so an address or data operation becomes visible to loads one cycle after it is accepted.

Stores leave in allocation order. A small drain state machine has two states: DRN_IDLE and DRN_WRITE. The transition DRN_IDLE to DRN_WRITE happens when a retire request is accepted, and a request is accepted only when the oldest slot holds its data. The transition DRN_WRITE to DRN_IDLE happens in the cycle the memory write port accepts the write, and that slot is freed in the same cycle. Otherwise the machine stays in its current state.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty. `sa_ready` is 1, `sa_tag` is 0, and `rt_ready`, `mem_wr_valid`, `ld_stall` and `ld_fwd` are 0.
- R2: An address operation is accepted when `sa_valid` and `sa_ready` are both 1. It fills the slot named by `sa_tag`. Tags are given out in increasing order modulo 8, starting from 0, and `sa_tag` advances by one after each accepted address operation.
- R3: While 8 slots are occupied, `sa_ready` is 0. An address operation presented in that state changes nothing, and `sa_tag` keeps its value.
- R4: A data operation (`sd_valid`, `sd_tag`, `sd_data`) writes the data field of slot `sd_tag` only if that slot is occupied and its data is still missing. A data operation to a free slot, or to a slot that already holds data, is ignored.
- R5: A load whose youngest matching slot holds data sees `ld_fwd`=1 and `ld_data` equal to that slot's data in the same cycle, with `mem_rd_en`=0 and `ld_stall`=0.
- R6: A load whose youngest matching slot lacks data sees `ld_stall`=1 and `mem_rd_en`=0. The stall ends in the cycle after that slot's data operation is accepted.
- R7: A load that matches no occupied slot sees `mem_rd_en`=1, `mem_rd_addr` equal to `ld_addr` and `ld_data` equal to `mem_rd_data`, even while other slots still lack data.
- R8: When several occupied slots match a load, only the youngest of them decides between forwarding and stalling.
- R9: `rt_ready` is 1 only while the drain machine is in DRN_IDLE and the oldest slot holds data. An accepted retire raises `mem_wr_valid` in the next cycle. `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` then hold steady until `mem_wr_ready` is 1.
- R10: The slot being written is freed in the cycle its write is accepted, so from the next cycle on it no longer matches loads. Writes leave oldest slot first and carry that slot's address and data.
- R11: Loads never occupy a slot: `sa_tag` and `sa_ready` do not change because of a load, and with `ld_valid`=0 all load outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sa_valid | input | 1 | Address operation present |
| sa_addr | input | 32 | Store target address |
| sa_ready | output | 1 | A free slot exists |
| sa_tag | output | 3 | Slot an address operation would take |
| sd_valid | input | 1 | Data operation present |
| sd_tag | input | 3 | Slot the data belongs to |
| sd_data | input | 64 | Store value |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | 32 | Load address |
| ld_stall | output | 1 | Load must wait for store data |
| ld_fwd | output | 1 | Load answered from the buffer |
| ld_data | output | 64 | Load result |
| mem_rd_en | output | 1 | Load goes to memory |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_data | input | 64 | Memory read result, same cycle |
| rt_valid | input | 1 | Retire request for the oldest store |
| rt_ready | output | 1 | Retire can be accepted |
| mem_wr_valid | output | 1 | Memory write pending |
| mem_wr_addr | output | 32 | Memory write address |
| mem_wr_data | output | 64 | Memory write data |
| mem_wr_ready | input | 1 | Memory accepts the write |

## Verification
Directed sequences cover three cases. A data operation sent before its address operation must leave the slot empty, and a second data operation must not overwrite the first. Two pending stores to one address, the younger still without data, must stall a load, and the load must then forward once the younger store is filled. This separates youngest-match selection from oldest-match selection. A load to an unrelated address while data is outstanding must go straight to memory, which shows that a non-matching load does not wait on missing data. Random traffic then uses a pool of four addresses so that matches are frequent, and mixes in a memory write port that sometimes refuses writes. Both wrap the tag pointers and exercise the full and nearly empty states against a reference model kept in the bench.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [0:0] {
        DRN_IDLE  = 1'b0,
        DRN_WRITE = 1'b1
    } drain_state_e;
endpackage

// File: rtl/sb_alloc_ctrl.sv
// Head/tail pointers and occupancy of the circular slot array.
module sb_alloc_ctrl #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             free,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             full
);
    localparam int CNT_W = TAG_W + 1;

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (alloc) begin
                tail <= tail + 1'b1;
            end
            if (free) begin
                head <= head + 1'b1;
            end
            if (alloc && !free) begin
                count <= count + 1'b1;
            end else if (free && !alloc) begin
                count <= count - 1'b1;
            end
        end
    end

    assign full = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/sb_load_match.sv
// Finds the youngest occupied slot whose address equals the load address.
module sb_load_match #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]         a_vld,
    input  logic [DEPTH-1:0]         d_vld,
    input  logic [DEPTH-1:0][AW-1:0] addr_q,
    input  logic [DEPTH-1:0][DW-1:0] data_q,
    input  logic [TAG_W-1:0]         head,
    input  logic                     ld_valid,
    input  logic [AW-1:0]            ld_addr,
    output logic                     hit,
    output logic                     hit_ready,
    output logic [DW-1:0]            hit_data
);
    logic [TAG_W-1:0] sel;
    logic [TAG_W-1:0] idx;

    // Walk from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        idx = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + TAG_W'(k);
            if (ld_valid && a_vld[idx] && (addr_q[idx] == ld_addr)) begin
                hit = 1'b1;
                sel = idx;
            end
        end
    end

    assign hit_ready = hit && d_vld[sel];
    assign hit_data  = data_q[sel];
endmodule

// File: rtl/sb_drain_fsm.sv
// Retire handshake and in-order write-out of the oldest slot.
module sb_drain_fsm
    import sb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rt_valid,
    input  logic head_full,
    input  logic mem_wr_ready,
    output logic rt_ready,
    output logic mem_wr_valid,
    output logic free_head
);
    drain_state_e state_q;
    drain_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DRN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRN_IDLE: begin
                if (rt_valid && head_full) begin
                    state_d = DRN_WRITE;
                end
            end
            DRN_WRITE: begin
                if (mem_wr_ready) begin
                    state_d = DRN_IDLE;
                end
            end
            default: state_d = DRN_IDLE;
        endcase
    end

    always_comb begin
        rt_ready     = 1'b0;
        mem_wr_valid = 1'b0;
        free_head    = 1'b0;
        unique case (state_q)
            DRN_IDLE: begin
                rt_ready = head_full;
            end
            DRN_WRITE: begin
                mem_wr_valid = 1'b1;
                free_head    = mem_wr_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/store_buffer.sv
module store_buffer #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sa_valid,
    input  logic [AW-1:0]    sa_addr,
    output logic             sa_ready,
    output logic [TAG_W-1:0] sa_tag,
    input  logic             sd_valid,
    input  logic [TAG_W-1:0] sd_tag,
    input  logic [DW-1:0]    sd_data,
    input  logic             ld_valid,
    input  logic [AW-1:0]    ld_addr,
    output logic             ld_stall,
    output logic             ld_fwd,
    output logic [DW-1:0]    ld_data,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [DW-1:0]    mem_rd_data,
    input  logic             rt_valid,
    output logic             rt_ready,
    output logic             mem_wr_valid,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [DW-1:0]    mem_wr_data,
    input  logic             mem_wr_ready
);
    logic [DEPTH-1:0]         a_vld;
    logic [DEPTH-1:0]         d_vld;
    logic [DEPTH-1:0][AW-1:0] addr_q;
    logic [DEPTH-1:0][DW-1:0] data_q;

    logic [TAG_W-1:0] head;
    logic [TAG_W-1:0] tail;
    logic             full;
    logic             alloc;
    logic             fill;
    logic             free_head;
    logic             head_full;
    logic             hit;
    logic             hit_ready;
    logic [DW-1:0]    hit_data;

    assign sa_ready  = !full;
    assign sa_tag    = tail;
    assign alloc     = sa_valid && !full;
    assign fill      = sd_valid && a_vld[sd_tag] && !d_vld[sd_tag];
    assign head_full = a_vld[head] && d_vld[head];

    sb_alloc_ctrl #(.DEPTH(DEPTH)) u_alloc (
        .clk   (clk),
        .rst_n (rst_n),
        .alloc (alloc),
        .free  (free_head),
        .head  (head),
        .tail  (tail),
        .full  (full)
    );

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_vld[e]  <= 1'b0;
                d_vld[e]  <= 1'b0;
                addr_q[e] <= '0;
                data_q[e] <= '0;
            end else if (free_head && (head == TAG_W'(e))) begin
                a_vld[e] <= 1'b0;
                d_vld[e] <= 1'b0;
            end else if (alloc && (tail == TAG_W'(e))) begin
                a_vld[e]  <= 1'b1;
                d_vld[e]  <= 1'b0;
                addr_q[e] <= sa_addr;
            end else if (fill && (sd_tag == TAG_W'(e))) begin
                d_vld[e]  <= 1'b1;
                data_q[e] <= sd_data;
            end
        end
    end

    sb_load_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .a_vld     (a_vld),
        .d_vld     (d_vld),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .head      (head),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .hit       (hit),
        .hit_ready (hit_ready),
        .hit_data  (hit_data)
    );

    assign ld_fwd      = hit_ready;
    assign ld_stall    = hit && !hit_ready;
    assign mem_rd_en   = ld_valid && !hit;
    assign mem_rd_addr = ld_addr;
    assign ld_data     = hit_ready ? hit_data : (mem_rd_en ? mem_rd_data : '0);

    sb_drain_fsm u_drain (
        .clk          (clk),
        .rst_n        (rst_n),
        .rt_valid     (rt_valid),
        .head_full    (head_full),
        .mem_wr_ready (mem_wr_ready),
        .rt_ready     (rt_ready),
        .mem_wr_valid (mem_wr_valid),
        .free_head    (free_head)
    );

    assign mem_wr_addr = addr_q[head];
    assign mem_wr_data = data_q[head];
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 64,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sa_valid,
    input logic             sa_ready,
    input logic [TAG_W-1:0] sa_tag,
    input logic             ld_valid,
    input logic             ld_stall,
    input logic             ld_fwd,
    input logic             mem_rd_en,
    input logic             rt_ready,
    input logic             mem_wr_valid,
    input logic             mem_wr_ready,
    input logic [AW-1:0]    mem_wr_addr,
    input logic [DW-1:0]    mem_wr_data
);
    logic [TAG_W:0] occ;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            occ <= occ + (TAG_W+1)'(sa_valid && sa_ready)
                       - (TAG_W+1)'(mem_wr_valid && mem_wr_ready);
        end
    end

    // R3
    full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == (TAG_W+1)'(DEPTH)) |-> !sa_ready);

    // R2
    tag_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sa_valid && sa_ready) |=> (sa_tag == $past(sa_tag) + 1'b1));

    // R5
    fwd_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fwd |-> (!mem_rd_en && !ld_stall));

    // R6
    stall_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall |-> !mem_rd_en);

    // R7
    miss_to_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_stall && !ld_fwd) |-> mem_rd_en);

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R9
    retire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_ready |-> !mem_wr_valid);

    // R11
    idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> (!mem_rd_en && !ld_stall && !ld_fwd));
endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sa_valid     (sa_valid),
    .sa_ready     (sa_ready),
    .sa_tag       (sa_tag),
    .ld_valid     (ld_valid),
    .ld_stall     (ld_stall),
    .ld_fwd       (ld_fwd),
    .mem_rd_en    (mem_rd_en),
    .rt_ready     (rt_ready),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data)
);

// File: tb/test_store_buffer.sv
module test_store_buffer;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sa_valid = 1'b0;
    logic [31:0] sa_addr = '0;
    logic        sa_ready;
    logic [2:0]  sa_tag;
    logic        sd_valid = 1'b0;
    logic [2:0]  sd_tag = '0;
    logic [63:0] sd_data = '0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_addr = '0;
    logic        ld_stall;
    logic        ld_fwd;
    logic [63:0] ld_data;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [63:0] mem_rd_data;
    logic        rt_valid = 1'b0;
    logic        rt_ready;
    logic        mem_wr_valid;
    logic [31:0] mem_wr_addr;
    logic [63:0] mem_wr_data;
    logic        mem_wr_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign mem_rd_data = {32'hC0DE_0000 ^ mem_rd_addr, ~mem_rd_addr};

    store_buffer i_store_buffer (
        .clk(clk), .rst_n(rst_n),
        .sa_valid(sa_valid), .sa_addr(sa_addr), .sa_ready(sa_ready), .sa_tag(sa_tag),
        .sd_valid(sd_valid), .sd_tag(sd_tag), .sd_data(sd_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_stall(ld_stall), .ld_fwd(ld_fwd),
        .ld_data(ld_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .rt_valid(rt_valid), .rt_ready(rt_ready),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready)
    );

    // Reference model
    bit          m_av [DEPTH];
    bit          m_dv [DEPTH];
    logic [31:0] m_addr [DEPTH];
    logic [63:0] m_data [DEPTH];
    int          m_head = 0;
    int          m_tail = 0;
    int          m_cnt = 0;
    bit          m_wr = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic void exp_load(input logic [31:0] a, output bit hit,
                                     output bit rdy, output logic [63:0] d);
        hit = 1'b0; rdy = 1'b0; d = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int ix = (m_head + k) % DEPTH;
            if (m_av[ix] && m_addr[ix] == a) begin
                hit = 1'b1; rdy = m_dv[ix]; d = m_data[ix];
            end
        end
    endfunction

    task automatic settle_and_check();
        bit hit, rdy;
        logic [63:0] d;
        bit exp_rt;
        #4;
        chk(m_cnt == DEPTH ? "R3 sa_ready" : "R2 sa_ready", 64'(sa_ready), 64'(m_cnt < DEPTH));
        chk("R2 sa_tag", 64'(sa_tag), 64'(m_tail));
        exp_rt = !m_wr && m_av[m_head] && m_dv[m_head];
        chk("R9 rt_ready", 64'(rt_ready), 64'(exp_rt));
        chk("R9 mem_wr_valid", 64'(mem_wr_valid), 64'(m_wr));
        if (m_wr) begin
            chk("R10 mem_wr_addr", 64'(mem_wr_addr), 64'(m_addr[m_head]));
            chk("R10 mem_wr_data", mem_wr_data, m_data[m_head]);
        end
        if (ld_valid) begin
            exp_load(ld_addr, hit, rdy, d);
            if (hit && rdy) begin
                chk("R5 ld_fwd", 64'(ld_fwd), 64'd1);
                chk("R5 ld_data", ld_data, d);
                chk("R5 mem_rd_en", 64'(mem_rd_en), 64'd0);
            end else if (hit) begin
                chk("R6 ld_stall", 64'(ld_stall), 64'd1);
                chk("R6 mem_rd_en", 64'(mem_rd_en), 64'd0);
            end else begin
                chk("R7 mem_rd_en", 64'(mem_rd_en), 64'd1);
                chk("R7 ld_stall", 64'(ld_stall), 64'd0);
                chk("R7 ld_data", ld_data, {32'hC0DE_0000 ^ ld_addr, ~ld_addr});
            end
        end else begin
            chk("R11 idle load outputs", {61'd0, mem_rd_en, ld_stall, ld_fwd}, 64'd0);
        end
    endtask

    task automatic commit();
        bit sa_f, sd_f, rt_f, wr_f;
        sa_f = sa_valid && m_cnt < DEPTH;
        sd_f = sd_valid && m_av[sd_tag] && !m_dv[sd_tag];
        rt_f = !m_wr && rt_valid && m_av[m_head] && m_dv[m_head];
        wr_f = m_wr && mem_wr_ready;
        @(posedge clk);
        if (sd_f) begin
            m_dv[sd_tag] = 1'b1;
            m_data[sd_tag] = sd_data;
        end
        if (wr_f) begin
            m_av[m_head] = 1'b0;
            m_dv[m_head] = 1'b0;
            m_head = (m_head + 1) % DEPTH;
            m_cnt--;
            m_wr = 1'b0;
        end
        if (rt_f) m_wr = 1'b1;
        if (sa_f) begin
            m_av[m_tail] = 1'b1;
            m_dv[m_tail] = 1'b0;
            m_addr[m_tail] = sa_addr;
            m_tail = (m_tail + 1) % DEPTH;
            m_cnt++;
        end
        @(negedge clk);
    endtask

    task automatic cycle();
        settle_and_check();
        commit();
    endtask

    task automatic idle_inputs();
        sa_valid = 0; sd_valid = 0; ld_valid = 0; rt_valid = 0; mem_wr_ready = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5521));
        for (int i = 0; i < DEPTH; i++) begin
            m_av[i] = 0; m_dv[i] = 0; m_addr[i] = '0; m_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #4;
        chk("R1 sa_ready", 64'(sa_ready), 64'd1);
        chk("R1 sa_tag", 64'(sa_tag), 64'd0);
        chk("R1 rt_ready", 64'(rt_ready), 64'd0);
        chk("R1 mem_wr_valid", 64'(mem_wr_valid), 64'd0);
        chk("R1 ld flags", {62'd0, ld_stall, ld_fwd}, 64'd0);
        @(negedge clk);

        // R4: data before address is ignored
        sd_valid = 1; sd_tag = 0; sd_data = 64'hDEAD;
        cycle();
        idle_inputs();
        sa_valid = 1; sa_addr = 32'h100;
        cycle();
        idle_inputs();
        ld_valid = 1; ld_addr = 32'h100;
        #4;
        chk("R4 early data ignored (stall)", 64'(ld_stall), 64'd1);
        commit();

        // R6: stall clears the cycle after the data operation
        idle_inputs();
        ld_valid = 1; ld_addr = 32'h100;
        sd_valid = 1; sd_tag = 0; sd_data = 64'h1111_2222_3333_4444;
        #4;
        chk("R6 stall during fill cycle", 64'(ld_stall), 64'd1);
        commit();
        sd_valid = 1; sd_tag = 0; sd_data = 64'h9999;
        #4;
        chk("R6 stall cleared", 64'(ld_stall), 64'd0);
        chk("R5 forwarded data", ld_data, 64'h1111_2222_3333_4444);
        commit();
        idle_inputs();
        ld_valid = 1; ld_addr = 32'h100;
        #4;
        chk("R4 second fill ignored", ld_data, 64'h1111_2222_3333_4444);
        commit();

        // R8: two matches, younger lacks data
        idle_inputs();
        sa_valid = 1; sa_addr = 32'h200; cycle();
        sd_valid = 1; sd_tag = 1; sd_data = 64'hAAAA; sa_addr = 32'h200; cycle();
        idle_inputs();
        ld_valid = 1; ld_addr = 32'h200;
        #4;
        chk("R8 youngest without data stalls", 64'(ld_stall), 64'd1);
        commit();
        // R7: unrelated load goes to memory while data outstanding
        ld_addr = 32'h300;
        #4;
        chk("R7 miss with outstanding data", 64'(mem_rd_en), 64'd1);
        chk("R11 tag unchanged by loads", 64'(sa_tag), 64'd3);
        commit();
        idle_inputs();
        sd_valid = 1; sd_tag = 2; sd_data = 64'hBBBB; cycle();
        idle_inputs();
        ld_valid = 1; ld_addr = 32'h200;
        #4;
        chk("R8 youngest match forwards", ld_data, 64'hBBBB);
        commit();

        // R9/R10: retire with delayed memory accept
        idle_inputs();
        rt_valid = 1; cycle();
        rt_valid = 0; mem_wr_ready = 0; cycle(); cycle();
        mem_wr_ready = 1;
        #4;
        chk("R10 oldest address first", 64'(mem_wr_addr), 64'h100);
        commit();
        idle_inputs();
        ld_valid = 1; ld_addr = 32'h100;
        #4;
        chk("R10 freed slot no longer matches", 64'(mem_rd_en), 64'd1);
        commit();

        // R3: fill up, then one refused allocation
        idle_inputs();
        for (int i = 0; i < 6; i++) begin
            sa_valid = 1; sa_addr = 32'h400 + 32'(i); cycle();
        end
        sa_valid = 1; sa_addr = 32'h500;
        #4;
        chk("R3 full refuses", 64'(sa_ready), 64'd0);
        commit();
        idle_inputs();
        ld_valid = 1; ld_addr = 32'h500;
        #4;
        chk("R3 refused address not stored", 64'(mem_rd_en), 64'd1);
        commit();

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            sa_valid     = ($urandom % 3) == 0;
            sa_addr      = 32'h100 * (1 + ($urandom % 4));
            sd_valid     = ($urandom % 2) == 0;
            sd_tag       = 3'($urandom);
            sd_data      = {$urandom, $urandom};
            ld_valid     = ($urandom % 2) == 0;
            ld_addr      = 32'h100 * (1 + ($urandom % 4));
            rt_valid     = ($urandom % 2) == 0;
            mem_wr_ready = ($urandom % 5) < 3;
            cycle();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule